// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block sits behind a clock-recovery and channel-demultiplexing front end. It takes one serial bit each time a bit strobe is high and finds command frames on an idle-high line. Each frame starts with a 0 start bit. A format bit follows, which selects a short frame (8 payload bits) or a long frame (14-bit receiver address, internal/external select, 8-bit sub-address, 8-bit data). Every payload is protected by a single-error-correcting, double-error-detecting Hamming code, and the frame ends with a 1 stop bit.

A good frame produces a one-cycle command strobe with the corrected fields. A frame with a correctable error also produces the strobe, with the error corrected. An uncorrectable frame, or a frame with a bad stop bit, is dropped. Long frames are kept only when their address matches the local address or is zero; address zero means broadcast. Three saturating counters record corrections, uncorrectable frames and framing faults. Each counter can be cleared on its own.

Top module: `cmd_frame_decoder`

## Requirements
- R1: The decoder samples `ser_in` only in cycles where `bit_en` is 1. While hunting, it ignores 1s and starts a frame at the first sampled 0. It never raises an output strobe or flag unless a frame has just ended.
- R2: Short frame: start 0, format 0, then 8 data bits MSB first, then the 5-bit check field MSB first, then stop 1. On the clock edge after the edge that samples the stop bit, `cmd_valid` pulses for one cycle with `cmd_long`=0 and `cmd_data` equal to the byte.
- R3: Long frame: start 0, format 1, then a 31-bit payload sent MSB first, then the 7-bit check field MSB first, then stop 1. The payload is {address[13:0], select, sub-address[7:0], data[7:0]}. A good frame gives `cmd_long`=1 and all fields, with the same timing as R2.
- R4: Check code: payload bit i (bit 0 = LSB) takes the i-th Hamming position that is not a power of two (3, 5, 6, 7, 9, ...). Check bit k is the XOR of the payload bits whose position has bit k set; there are 4 such bits for short frames and 6 for long. The top check bit is even parity over the payload and all the other check bits. An error-free frame raises no error flag.
- R5: A frame with exactly one flipped bit, whether in the payload or the check field, is delivered with the original field values. `err_fixed` pulses together with `cmd_valid`.
- R6: A frame with two flipped bits produces no `cmd_valid`, and `err_uncorr` pulses at the cycle where the strobe would have come.
- R7: A 0 in the stop position produces no `cmd_valid` and pulses `err_framing`. The decoder then hunts for the next start bit, and the next frame is decoded normally.
- R8: A long frame is accepted only if its address equals `own_addr` or is zero. `cmd_bcast`=1 exactly when an accepted long frame has address zero. An error-free long frame with any other address produces no output.
- R9: Each of `err_fixed`, `err_uncorr` and `err_framing` adds one to its counter (`cnt_fixed`, `cnt_uncorr`, `cnt_framing`). A counter that is at all ones stays there.
- R10: `cnt_clr` bit 0 clears `cnt_fixed`, bit 1 clears `cnt_uncorr` and bit 2 clears `cnt_framing`, effective on the next edge. If a clear and an increment of the same counter fall on the same edge, the counter becomes 1.
- R11: After a synchronous active-low reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries a serial bit |
| ser_in | input | 1 | Serial command channel |
| own_addr | input | 14 | Local receiver address for long frames |
| cnt_clr | input | 3 | Per-counter clear (fixed, uncorrectable, framing) |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_long | output | 1 | Accepted command came from a long frame |
| cmd_bcast | output | 1 | Accepted long frame had address zero |
| cmd_addr | output | 14 | Receiver address field |
| cmd_ext | output | 1 | Internal/external select field |
| cmd_subaddr | output | 8 | Sub-address field |
| cmd_data | output | 8 | Data byte |
| err_fixed | output | 1 | Single-bit error corrected in the frame just ended |
| err_uncorr | output | 1 | Uncorrectable frame dropped |
| err_framing | output | 1 | Stop bit missing, frame dropped |
| cnt_fixed | output | CNT_W | Saturating count of corrections |
| cnt_uncorr | output | CNT_W | Saturating count of uncorrectable frames |
| cnt_framing | output | CNT_W | Saturating count of framing faults |

## Verification
Two functions can land on the same clock edge: a counter clear written from outside, and the increment of that same counter caused by a frame that has just ended. The bench provokes this by raising `cnt_clr` in the cycle after it drives a stop bit, so the clear is sampled on the same edge that registers the error flag. This is done for a corrected frame and for an uncorrectable one. The reference model applies the clear before the increment and expects a count of exactly 1. The bench compares that count, and all other outputs, on every clock against the model.

// File: rtl/cfd_pkg.sv
// Shared constants, receiver state type and the SEC-DED encoder for the
// command frame decoder. The bench uses the same encoder to build frames.
package cfd_pkg;

    localparam int ADDR_W   = 14;
    localparam int SUB_W    = 8;
    localparam int DATA_W   = 8;
    localparam int SHORT_ND = DATA_W;                       // short payload bits
    localparam int SHORT_NH = 4;                            // Hamming bits, short
    localparam int LONG_ND  = ADDR_W + 1 + SUB_W + DATA_W;  // 31
    localparam int LONG_NH  = 6;                            // Hamming bits, long
    localparam int SHORT_CW = SHORT_ND + SHORT_NH + 1;      // 13
    localparam int LONG_CW  = LONG_ND + LONG_NH + 1;        // 38
    localparam int N_CNT    = 3;

    typedef enum logic [1:0] {RX_HUNT, RX_FMT, RX_BODY, RX_STOP} rx_state_e;

    // Hamming position (non power of two, from 3) of payload bit idx.
    function automatic int hpos(input int idx);
        int n;
        int result;
        n = 0;
        result = 0;
        for (int p = 3; p < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx && result == 0) result = p;
                n++;
            end
        end
        return result;
    endfunction

    // Check field: bits [nh-1:0] Hamming, bit nh overall even parity.
    function automatic logic [7:0] secded_check(input logic [30:0] d,
                                                input int nd, input int nh);
        logic [7:0] c;
        logic       par;
        c   = '0;
        par = 1'b0;
        for (int i = 0; i < 31; i++) begin
            if (i < nd) begin
                int p;
                p   = hpos(i);
                par = par ^ d[i];
                for (int k = 0; k < 7; k++) begin
                    if (k < nh && p[k]) c[k] = c[k] ^ d[i];
                end
            end
        end
        for (int k = 0; k < 7; k++) begin
            if (k < nh) par = par ^ c[k];
        end
        c[nh] = par;
        return c;
    endfunction

endpackage

// File: rtl/cfd_secded.sv
// SEC-DED checker for one frame length.
// Recomputes the check field and forms the syndrome. It corrects a single
// flipped payload bit and reports whether the codeword was correctable.
// Assumes the check-field layout produced by cfd_pkg::secded_check.
module cfd_secded
    import cfd_pkg::*;
#(
    parameter int ND = 8,
    parameter int NH = 4
) (
    input  logic [ND-1:0] data_in,
    input  logic [NH:0]   chk_in,
    output logic [ND-1:0] data_out,
    output logic          err_fix,
    output logic          err_bad
);

    logic [30:0]   d_ext;
    logic [NH:0]   recalc;
    logic [NH-1:0] syn;
    logic          ovr;
    logic          hit;
    logic          pow2;
    logic          fixable;

    assign d_ext  = 31'(data_in);
    assign recalc = (NH+1)'(secded_check(d_ext, ND, NH));
    assign syn    = recalc[NH-1:0] ^ chk_in[NH-1:0];
    // Parity over the whole received codeword, derived from the recomputed field.
    assign ovr    = recalc[NH] ^ chk_in[NH] ^ (^syn);
    assign pow2   = ($countones(syn) == 1);

    // Flip the payload bit that the syndrome points at, when parity says single.
    always_comb begin
        data_out = data_in;
        hit      = 1'b0;
        for (int i = 0; i < ND; i++) begin
            if (ovr && hpos(i) == int'(syn)) begin
                data_out[i] = ~data_in[i];
                hit         = 1'b1;
            end
        end
    end

    assign fixable = (syn == '0) || hit || pow2;
    assign err_fix = ovr && fixable;
    assign err_bad = (!ovr && syn != '0) || (ovr && !fixable);

endmodule

// File: rtl/cfd_frame_rx.sv
// Serial frame receiver.
// Hunts for a start bit, reads the format bit, then shifts in the codeword
// whose length the format bit selects, and finally checks the stop bit.
// Assumes one bit per cycle where bit_en is high; other cycles are ignored.
module cfd_frame_rx
    import cfd_pkg::*;
#(
    parameter int LCW = LONG_CW,
    parameter int SCW = SHORT_CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_en,
    input  logic           ser_in,
    output logic           frame_rdy,
    output logic           stop_err,
    output logic           is_long,
    output logic [LCW-1:0] cw
);

    localparam int CNT_W = $clog2(LCW + 1);

    rx_state_e        st;
    logic [CNT_W-1:0] left;

    // Frame sequencing: hunt, format, body shift, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= RX_HUNT;
            left      <= '0;
            is_long   <= 1'b0;
            cw        <= '0;
            frame_rdy <= 1'b0;
            stop_err  <= 1'b0;
        end else begin
            frame_rdy <= 1'b0;
            stop_err  <= 1'b0;
            if (bit_en) begin
                case (st)
                    RX_HUNT: if (!ser_in) st <= RX_FMT;
                    RX_FMT: begin
                        is_long <= ser_in;
                        left    <= ser_in ? CNT_W'(LCW - 1) : CNT_W'(SCW - 1);
                        st      <= RX_BODY;
                    end
                    RX_BODY: begin
                        cw <= {cw[LCW-2:0], ser_in};
                        if (left == '0) st <= RX_STOP;
                        else            left <= left - 1'b1;
                    end
                    RX_STOP: begin
                        if (ser_in) frame_rdy <= 1'b1;
                        else        stop_err  <= 1'b1;
                        st <= RX_HUNT;
                    end
                    default: st <= RX_HUNT;
                endcase
            end
        end
    end

    // R1: without a strobe the sequencer does not move and raises nothing.
    p_hold_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(st) && !frame_rdy && !stop_err));

    // R7: a frame ends either good or with a framing fault, never both.
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_rdy && stop_err));

    // R7: after any frame end the receiver is hunting again.
    p_back_to_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rdy || stop_err) |-> st == RX_HUNT);

endmodule

// File: rtl/cfd_sat_counter.sv
// Saturating event counter with a clear input.
// A clear on the same edge as an increment leaves the value 1.
module cfd_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // Count events, hold at all ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= W'(inc);
        else if (inc && cnt != '1)     cnt <= cnt + 1'b1;
    end

    // R9: a counter at all ones never wraps.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !clr) |=> cnt == '1);

    // R9: without clear the counter moves by at most one.
    p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R10: clear leaves only the coincident event.
    p_clear_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == W'($past(inc)));

endmodule

// File: rtl/cmd_frame_decoder.sv
// Command frame decoder top.
// Receives short and long frames, checks and corrects them with SEC-DED,
// applies the address filter and registers the accepted command. It also
// keeps three saturating error counters.
// Assumes bit_en marks valid serial bits and that own_addr is quasi-static.
module cmd_frame_decoder
    import cfd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [N_CNT-1:0]  cnt_clr,
    output logic              cmd_valid,
    output logic              cmd_long,
    output logic              cmd_bcast,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ext,
    output logic [SUB_W-1:0]  cmd_subaddr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              err_fixed,
    output logic              err_uncorr,
    output logic              err_framing,
    output logic [CNT_W-1:0]  cnt_fixed,
    output logic [CNT_W-1:0]  cnt_uncorr,
    output logic [CNT_W-1:0]  cnt_framing
);

    logic               frame_rdy;
    logic               stop_err;
    logic               is_long;
    logic [LONG_CW-1:0] cw;

    cfd_frame_rx #(.LCW(LONG_CW), .SCW(SHORT_CW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .ser_in    (ser_in),
        .frame_rdy (frame_rdy),
        .stop_err  (stop_err),
        .is_long   (is_long),
        .cw        (cw)
    );

    logic [SHORT_ND-1:0] s_data;
    logic                s_fix;
    logic                s_bad;
    logic [LONG_ND-1:0]  l_data;
    logic                l_fix;
    logic                l_bad;

    cfd_secded #(.ND(SHORT_ND), .NH(SHORT_NH)) u_chk_short (
        .data_in  (cw[SHORT_CW-1:SHORT_NH+1]),
        .chk_in   (cw[SHORT_NH:0]),
        .data_out (s_data),
        .err_fix  (s_fix),
        .err_bad  (s_bad)
    );

    cfd_secded #(.ND(LONG_ND), .NH(LONG_NH)) u_chk_long (
        .data_in  (cw[LONG_CW-1:LONG_NH+1]),
        .chk_in   (cw[LONG_NH:0]),
        .data_out (l_data),
        .err_fix  (l_fix),
        .err_bad  (l_bad)
    );

    logic [ADDR_W-1:0] l_addr;
    logic              l_ext;
    logic [SUB_W-1:0]  l_sub;
    logic [DATA_W-1:0] l_dat;
    logic              fix_sel;
    logic              bad_sel;
    logic              addr_ok;
    logic              accept;

    assign {l_addr, l_ext, l_sub, l_dat} = l_data;
    assign fix_sel = is_long ? l_fix : s_fix;
    assign bad_sel = is_long ? l_bad : s_bad;
    assign addr_ok = !is_long || l_addr == '0 || l_addr == own_addr;
    assign accept  = frame_rdy && !bad_sel && addr_ok;

    // Register the command strobe, error flags and the accepted fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid   <= 1'b0;
            cmd_long    <= 1'b0;
            cmd_bcast   <= 1'b0;
            cmd_addr    <= '0;
            cmd_ext     <= 1'b0;
            cmd_subaddr <= '0;
            cmd_data    <= '0;
            err_fixed   <= 1'b0;
            err_uncorr  <= 1'b0;
            err_framing <= 1'b0;
        end else begin
            cmd_valid   <= accept;
            err_fixed   <= frame_rdy && fix_sel;
            err_uncorr  <= frame_rdy && bad_sel;
            err_framing <= stop_err;
            if (accept) begin
                cmd_long    <= is_long;
                cmd_bcast   <= is_long && l_addr == '0;
                cmd_addr    <= is_long ? l_addr : '0;
                cmd_ext     <= is_long && l_ext;
                cmd_subaddr <= is_long ? l_sub : '0;
                cmd_data    <= is_long ? l_dat : s_data;
            end
        end
    end

    logic [N_CNT-1:0] inc_v;
    logic [CNT_W-1:0] cnt_v [N_CNT];

    assign inc_v = {stop_err, frame_rdy && bad_sel, frame_rdy && fix_sel};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        cfd_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_v[g]),
            .clr   (cnt_clr[g]),
            .cnt   (cnt_v[g])
        );
    end

    assign cnt_fixed   = cnt_v[0];
    assign cnt_uncorr  = cnt_v[1];
    assign cnt_framing = cnt_v[2];

    // R2: a command strobe only follows a frame whose stop bit was good.
    p_strobe_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(frame_rdy));

    // R6: a strobe never coincides with a dropped-frame flag.
    p_clean_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (!err_uncorr && !err_framing));

    // R8: an accepted long command is addressed to this receiver or broadcast.
    p_addr_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_long) |-> (cmd_addr == '0 || cmd_addr == $past(own_addr)));

    // R8: broadcast marking only for long frames.
    p_bcast_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_bcast) |-> cmd_long);

endmodule

// File: tb/sim_cmd_frame_decoder.sv
// Bench: drives frames bit by bit and predicts each output in a behavioural
// model (time slots, integers); every output is compared on every clock.
module sim_cmd_frame_decoder;
    import cfd_pkg::*;

    localparam int CW_BITS = 4;
    localparam int CMAX    = (1 << CW_BITS) - 1;
    localparam logic [13:0] OWN = 14'h1A5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n, bit_en, ser_in;
    logic [2:0]         cnt_clr;
    logic               cmd_valid, cmd_long, cmd_bcast, cmd_ext;
    logic [13:0]        cmd_addr;
    logic [7:0]         cmd_subaddr, cmd_data;
    logic               err_fixed, err_uncorr, err_framing;
    logic [CW_BITS-1:0] cnt_fixed, cnt_uncorr, cnt_framing;

    cmd_frame_decoder #(.CNT_W(CW_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
        .own_addr(OWN), .cnt_clr(cnt_clr),
        .cmd_valid(cmd_valid), .cmd_long(cmd_long), .cmd_bcast(cmd_bcast),
        .cmd_addr(cmd_addr), .cmd_ext(cmd_ext), .cmd_subaddr(cmd_subaddr),
        .cmd_data(cmd_data), .err_fixed(err_fixed), .err_uncorr(err_uncorr),
        .err_framing(err_framing), .cnt_fixed(cnt_fixed),
        .cnt_uncorr(cnt_uncorr), .cnt_framing(cnt_framing)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit run = 1'b0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected events, kept in slots indexed by cycle modulo 8.
    bit        ev_on [8];
    bit        ev_valid [8], ev_long [8], ev_bc [8], ev_ext [8];
    bit [13:0] ev_addr [8];
    bit [7:0]  ev_sub [8], ev_dat [8];
    bit        ev_fix [8], ev_bad [8], ev_frm [8];
    string     ev_tag [8];
    bit [2:0]  clr_ev [8];
    int        m_cnt [3];

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Reference model and comparison, away from the active edge.
    always @(negedge clk) begin
        if (run) begin
            int s;
            s = cyc % 8;
            for (int k = 0; k < 3; k++) if (clr_ev[s][k]) m_cnt[k] = 0;
            clr_ev[s] = 3'b000;
            if (ev_on[s]) begin
                if (ev_fix[s] && m_cnt[0] < CMAX) m_cnt[0]++;
                if (ev_bad[s] && m_cnt[1] < CMAX) m_cnt[1]++;
                if (ev_frm[s] && m_cnt[2] < CMAX) m_cnt[2]++;
                check(ev_tag[s], "cmd_valid", 32'(cmd_valid), 32'(ev_valid[s]));
                if (ev_valid[s]) begin
                    check(ev_tag[s], "cmd_long", 32'(cmd_long), 32'(ev_long[s]));
                    check(ev_tag[s], "cmd_data", 32'(cmd_data), 32'(ev_dat[s]));
                    if (ev_long[s]) begin
                        check(ev_tag[s], "cmd_addr", 32'(cmd_addr), 32'(ev_addr[s]));
                        check(ev_tag[s], "cmd_ext", 32'(cmd_ext), 32'(ev_ext[s]));
                        check(ev_tag[s], "cmd_subaddr", 32'(cmd_subaddr), 32'(ev_sub[s]));
                        check(ev_tag[s], "cmd_bcast", 32'(cmd_bcast), 32'(ev_bc[s]));
                    end
                end
                check(ev_tag[s], "err_fixed", 32'(err_fixed), 32'(ev_fix[s]));
                check(ev_tag[s], "err_uncorr", 32'(err_uncorr), 32'(ev_bad[s]));
                check(ev_tag[s], "err_framing", 32'(err_framing), 32'(ev_frm[s]));
                ev_on[s] = 1'b0;
            end else begin
                check("R1", "quiet flags",
                      32'({cmd_valid, err_fixed, err_uncorr, err_framing}), 32'd0);
            end
            check("R9,R10", "cnt_fixed", 32'(cnt_fixed), 32'(m_cnt[0]));
            check("R9,R10", "cnt_uncorr", 32'(cnt_uncorr), 32'(m_cnt[1]));
            check("R9,R10", "cnt_framing", 32'(cnt_framing), 32'(m_cnt[2]));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc == 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // One serial bit; the gap cycle drives the opposite level (R1).
    task automatic drive_bit(input logic b);
        @(negedge clk);
        ser_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        ser_in = ~b;
    endtask

    task automatic idle(input int n);
        repeat (n) drive_bit(1'b1);
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        @(negedge clk);
        cnt_clr = m;
        clr_ev[(cyc + 1) % 8] = m;
        @(negedge clk);
        cnt_clr = 3'b000;
    endtask

    // Build, corrupt and send one frame; schedule the expected result.
    task automatic send_frame(input bit lng, input logic [13:0] a, input bit e,
                              input logic [7:0] sb, input logic [7:0] d,
                              input int f1, input int f2, input bit bad_stop,
                              input logic [2:0] co_clr, input string tag);
        logic [37:0] cw;
        logic [30:0] pl;
        logic [7:0]  ck;
        int n, nflip, t, s;
        if (lng) begin
            pl = {a, e, sb, d};
            ck = secded_check(pl, LONG_ND, LONG_NH);
            cw = {pl, ck[6:0]};
            n  = LONG_CW;
        end else begin
            pl = 31'(d);
            ck = secded_check(pl, SHORT_ND, SHORT_NH);
            cw = {25'd0, d, ck[4:0]};
            n  = SHORT_CW;
        end
        nflip = 0;
        if (f1 >= 0) begin cw[f1] = ~cw[f1]; nflip++; end
        if (f2 >= 0) begin cw[f2] = ~cw[f2]; nflip++; end
        drive_bit(1'b0);
        drive_bit(lng);
        for (int i = n - 1; i >= 0; i--) drive_bit(cw[i]);
        @(negedge clk);
        ser_in = !bad_stop;
        bit_en = 1'b1;
        t = cyc;
        s = (t + 2) % 8;
        ev_on[s]    = 1'b1;
        ev_tag[s]   = tag;
        ev_frm[s]   = bad_stop;
        ev_bad[s]   = !bad_stop && nflip == 2;
        ev_fix[s]   = !bad_stop && nflip == 1;
        ev_valid[s] = !bad_stop && nflip < 2 && (!lng || a == 14'd0 || a == OWN);
        ev_long[s]  = lng;
        ev_bc[s]    = lng && a == 14'd0;
        ev_addr[s]  = a;
        ev_ext[s]   = e;
        ev_sub[s]   = sb;
        ev_dat[s]   = d;
        @(negedge clk);
        bit_en = 1'b0;
        ser_in = 1'b1;
        cnt_clr = co_clr;
        clr_ev[(cyc + 1) % 8] = co_clr;
        @(negedge clk);
        cnt_clr = 3'b000;
    endtask

    initial begin
        rst_n = 1'b0;
        bit_en = 1'b0;
        ser_in = 1'b1;
        cnt_clr = 3'b000;
        repeat (3) @(negedge clk);
        // R11: reset state of every output.
        check("R11", "strobes", 32'({cmd_valid, cmd_long, cmd_bcast, cmd_ext,
              err_fixed, err_uncorr, err_framing}), 32'd0);
        check("R11", "fields", 32'({cmd_addr, cmd_subaddr, cmd_data}), 32'd0);
        check("R11", "counters", 32'({cnt_fixed, cnt_uncorr, cnt_framing}), 32'd0);
        rst_n = 1'b1;
        run = 1'b1;
        idle(3);

        // R2, R4: clean short frames.
        send_frame(0, 14'd0, 0, 8'h00, 8'hA5, -1, -1, 0, 3'b000, "R2,R4");
        idle(2);
        send_frame(0, 14'd0, 0, 8'h00, 8'h00, -1, -1, 0, 3'b000, "R2,R4");
        send_frame(0, 14'd0, 0, 8'h00, 8'hFF, -1, -1, 0, 3'b000, "R2,R4");
        // R3, R4: clean long frames to this receiver.
        send_frame(1, OWN, 1, 8'h3C, 8'h96, -1, -1, 0, 3'b000, "R3,R4");
        send_frame(1, OWN, 0, 8'hC3, 8'h5A, -1, -1, 0, 3'b000, "R3,R4");
        // R8: broadcast and foreign address.
        send_frame(1, 14'd0, 1, 8'h11, 8'h22, -1, -1, 0, 3'b000, "R8");
        send_frame(1, 14'h2A5, 0, 8'h44, 8'h77, -1, -1, 0, 3'b000, "R8");
        // R5: single flips in payload, Hamming bits and overall bit.
        send_frame(0, 14'd0, 0, 8'h00, 8'h3E, 7, -1, 0, 3'b000, "R5");
        send_frame(0, 14'd0, 0, 8'h00, 8'h81, 1, -1, 0, 3'b000, "R5");
        send_frame(0, 14'd0, 0, 8'h00, 8'hC4, 4, -1, 0, 3'b000, "R5");
        send_frame(1, OWN, 1, 8'hE7, 8'h18, 20, -1, 0, 3'b000, "R5");
        send_frame(1, OWN, 0, 8'h09, 8'hF0, 0, -1, 0, 3'b000, "R5");
        send_frame(1, 14'd0, 1, 8'hAB, 8'hCD, 6, -1, 0, 3'b000, "R5");
        send_frame(1, OWN, 1, 8'h5D, 8'h6E, 37, -1, 0, 3'b000, "R5");
        // R6: double flips.
        send_frame(0, 14'd0, 0, 8'h00, 8'h69, 2, 9, 0, 3'b000, "R6");
        send_frame(1, OWN, 1, 8'h12, 8'h34, 10, 30, 0, 3'b000, "R6");
        // R7: missing stop bit, then recovery.
        send_frame(0, 14'd0, 0, 8'h00, 8'h55, -1, -1, 1, 3'b000, "R7");
        send_frame(1, OWN, 1, 8'h90, 8'h0F, -1, -1, 0, 3'b000, "R7");
        // R10: plain clear, then clear on the same edge as an increment.
        pulse_clr(3'b111);
        send_frame(0, 14'd0, 0, 8'h00, 8'h2D, 3, -1, 0, 3'b001, "R10");
        send_frame(1, OWN, 0, 8'h77, 8'h88, 5, 15, 0, 3'b010, "R10");
        // R9: framing counter runs into saturation.
        for (int i = 0; i < CMAX + 3; i++)
            send_frame(0, 14'd0, 0, 8'h00, 8'(i), -1, -1, 1, 3'b000, "R9");
        idle(2);
        pulse_clr(3'b100);
        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule